// File: doc/BRIEF.md
# External Clock Edge Conditioner

This block turns an asynchronous external clock pin into a clean, single-cycle count-enable pulse in the internal clock domain. It is meant to sit in front of a low-power counter. The raw pin first passes through a synchroniser. A digital filter then accepts a new level only after that level has held for a run-time selectable number of internal clock periods: none, 2, 4 or 8. The accepted level changes are converted into pulses on the rising edge, the falling edge or both edges.

A source-select field picks what drives the counter. It can be the conditioned external edges, or a free-running internal tick, which asserts the count enable on every internal clock cycle. The configuration is held in local registers. A write to them is taken only while the block is disabled. While disabled, the block also reloads its filter from the present synchronised pin level, so enabling it never produces a stale edge. An illegal polarity code is reported on an error output and silences the count enable.

Top module: `extcond_top`

## Requirements
- R1: The pin passes two synchroniser flops. With filter code 0 and rising-edge mode, a rise driven before clock edge k gives `countEn` high for exactly one cycle after edge k+2.
- R2: Filter code 0 accepts every synchronised level change, including changes that last only one internal clock period.
- R3: Filter codes 1, 2 and 3 accept a new level only after it has been sampled on 2, 4 or 8 consecutive clock edges. A shorter excursion, or one that returns to the accepted level even for a single sample, gives no pulse and restarts the stability count.
- R4: Polarity code 0 pulses on accepted rises, code 1 on accepted falls and code 2 on both. Each accepted active edge gives one pulse that is one cycle wide.
- R5: Polarity code 3 is illegal. While it is stored, `cfgError` is 1 and `countEn` stays 0 whatever the source selection.
- R6: With source select 0, `countEn` is 1 on every cycle after an edge that samples `enable` high. With source select 1, it follows the conditioned external edges.
- R7: A configuration write (`cfgWr` high at a clock edge) is stored only when `enable` is 0 at that edge. A write made while enabled has no effect on `cfgError` or on the pulses.
- R8: While `enable` is 0, `countEn` is 0 and the filter takes the current synchronised level as accepted. A pin level change made while disabled gives no pulse after enabling.
- R9: After reset, all configuration fields are 0 (no filter, rising edge, internal tick), `countEn` is 0 and `cfgError` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extIn | input | 1 | Raw asynchronous external clock pin |
| enable | input | 1 | Block enable; configuration writes are allowed only while this is 0 |
| cfgWr | input | 1 | Configuration write strobe |
| cfgFiltIn | input | 2 | Filter code: 0 none, 1/2/3 need 2/4/8 stable samples |
| cfgPolIn | input | 2 | Active edge code: 0 rise, 1 fall, 2 both, 3 illegal |
| cfgSelIn | input | 1 | Source select: 0 internal tick, 1 external edges |
| countEn | output | 1 | One-cycle count enable pulse |
| cfgError | output | 1 | Stored polarity code is illegal |

## Verification
Glitches one sample shorter than each filter length are contrasted with excursions of exactly that length. This separates an off-by-one stability count from a correct one. An excursion that is interrupted by a single opposite sample shows whether the count restarts. Square waves with the same hold length in the three edge modes give pulse counts of N, N and 2N. That tells a wrong edge choice from a missing edge. Long random runs of hold lengths, configurations, disable phases and locked writes are compared cycle by cycle against a bench model that is built from the stated latency and filter rules.

// File: rtl/extcond_pkg.sv
package extcond_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic run;      // block enabled
    logic blocked;  // illegal configuration, suppress output
    logic useExt;   // count external edges instead of internal tick
    logic riseAct;  // rising edge is active
    logic fallAct;  // falling edge is active
  } strobe_t;

  localparam logic [1:0] POL_RISE = 2'd0;
  localparam logic [1:0] POL_FALL = 2'd1;
  localparam logic [1:0] POL_BOTH = 2'd2;

endpackage

// File: rtl/extcond_ctrl.sv
module extcond_ctrl
  import extcond_pkg::*;
#(
  parameter int FILT_W = 2,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              cfgWr,
  input  logic [FILT_W-1:0] cfgFiltIn,
  input  logic [1:0]        cfgPolIn,
  input  logic              cfgSelIn,
  output strobe_t           strb,
  output logic [CNT_W-1:0]  needCount,
  output logic              cfgError
);

  logic [FILT_W-1:0] filtReg;
  logic [1:0]        polReg;
  logic              selReg;
  logic              wrTake;

  // Writes are accepted only while disabled
  assign wrTake = cfgWr & ~enable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtReg <= '0;
      polReg  <= POL_RISE;
      selReg  <= 1'b0;
    end else if (wrTake) begin
      filtReg <= cfgFiltIn;
      polReg  <= cfgPolIn;
      selReg  <= cfgSelIn;
    end
  end

  // Stability length is a power of two of the filter code
  assign needCount = CNT_W'(1) << filtReg;

  always_comb begin
    strb         = '0;
    strb.run     = enable;
    strb.useExt  = selReg;
    strb.riseAct = (polReg == POL_RISE) || (polReg == POL_BOTH);
    strb.fallAct = (polReg == POL_FALL) || (polReg == POL_BOTH);
    cfgError     = (polReg > POL_BOTH);
    strb.blocked = cfgError;
  end

  AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> $stable({filtReg, polReg, selReg})); // R7

  AST_ERR_NO_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> !(strb.riseAct || strb.fallAct)); // R5

endmodule

// File: rtl/extcond_datapath.sv
module extcond_datapath
  import extcond_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extIn,
  input  strobe_t          strb,
  input  logic [CNT_W-1:0] needCount,
  output logic             countEn
);

  logic [SYNC_STAGES-1:0] syncReg;
  logic                   syncLvl;
  logic                   acceptedLvl;
  logic [CNT_W-1:0]       stableCnt;
  logic [CNT_W-1:0]       cntNext;
  logic                   differs;
  logic                   accept;
  logic                   edgeHit;
  logic                   pulseNext;

  // Synchroniser chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncReg <= '0;
    else       syncReg <= {syncReg[SYNC_STAGES-2:0], extIn};
  end
  assign syncLvl = syncReg[SYNC_STAGES-1];

  // Stability filter
  always_comb begin
    differs = (syncLvl != acceptedLvl);
    cntNext = stableCnt + CNT_W'(1);
    accept  = strb.run && differs && (cntNext >= needCount);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acceptedLvl <= 1'b0;
      stableCnt   <= '0;
    end else if (!strb.run) begin
      acceptedLvl <= syncLvl;
      stableCnt   <= '0;
    end else if (!differs) begin
      stableCnt   <= '0;
    end else if (accept) begin
      acceptedLvl <= syncLvl;
      stableCnt   <= '0;
    end else begin
      stableCnt   <= cntNext;
    end
  end

  // Edge selection and output pulse
  always_comb begin
    edgeHit   = accept && (syncLvl ? strb.riseAct : strb.fallAct);
    pulseNext = strb.run && !strb.blocked && (strb.useExt ? edgeHit : 1'b1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) countEn <= 1'b0;
    else       countEn <= pulseNext;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    stableCnt < needCount); // R3

  AST_EDGE_CHANGED: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && $past(strb.useExt)) |-> (acceptedLvl != $past(acceptedLvl))); // R4

  AST_RISE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && $past(strb.useExt && strb.riseAct && !strb.fallAct)) |-> acceptedLvl); // R4

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.run) |-> !countEn); // R8

endmodule

// File: rtl/extcond_top.sv
module extcond_top
  import extcond_pkg::*;
#(
  parameter int FILT_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extIn,
  input  logic              enable,
  input  logic              cfgWr,
  input  logic [FILT_W-1:0] cfgFiltIn,
  input  logic [1:0]        cfgPolIn,
  input  logic              cfgSelIn,
  output logic              countEn,
  output logic              cfgError
);

  localparam int MAX_NEED = 1 << ((1 << FILT_W) - 1);
  localparam int CNT_W    = $clog2(MAX_NEED + 1);

  strobe_t          strb;
  logic [CNT_W-1:0] needCount;

  extcond_ctrl #(.FILT_W(FILT_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWr(cfgWr),
    .cfgFiltIn(cfgFiltIn), .cfgPolIn(cfgPolIn), .cfgSelIn(cfgSelIn),
    .strb(strb), .needCount(needCount), .cfgError(cfgError)
  );

  extcond_datapath #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .extIn(extIn), .strb(strb),
    .needCount(needCount), .countEn(countEn)
  );

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> !countEn); // R5

endmodule

// File: tb/extcond_top_tb.sv
module extcond_top_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       extIn = 1'b0;
  logic       enable = 1'b0;
  logic       cfgWr = 1'b0;
  logic [1:0] cfgFiltIn = '0;
  logic [1:0] cfgPolIn = '0;
  logic       cfgSelIn = 1'b0;
  logic       countEn;
  logic       cfgError;

  int nChecks = 0;
  int nFail   = 0;
  int pulseCnt;
  bit cmpOn = 1'b0;
  bit done  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  extcond_top u_dut (
    .clk(clk), .rstN(rstN), .extIn(extIn), .enable(enable), .cfgWr(cfgWr),
    .cfgFiltIn(cfgFiltIn), .cfgPolIn(cfgPolIn), .cfgSelIn(cfgSelIn),
    .countEn(countEn), .cfgError(cfgError)
  );

  // Behavioural expectation built from the requirements
  logic       mS1, mS2, mAcc, mCe, mSel, mEv, mMatch;
  logic [1:0] mF, mP;
  int         mCnt;

  function automatic int needOf(logic [1:0] f);
    return 1 << f;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1 <= 0; mS2 <= 0; mAcc <= 0; mCe <= 0; mCnt <= 0;
      mF <= 0; mP <= 0; mSel <= 0;
    end else begin
      mS1 <= extIn;
      mS2 <= mS1;
      if (cfgWr && !enable) begin
        mF <= cfgFiltIn; mP <= cfgPolIn; mSel <= cfgSelIn;
      end
      if (!enable) begin
        mAcc <= mS2; mCnt <= 0; mCe <= 0;
      end else begin
        mEv = 0;
        if (mS2 == mAcc) mCnt <= 0;
        else if (mCnt + 1 >= needOf(mF)) begin
          mAcc <= mS2; mCnt <= 0; mEv = 1;
        end else mCnt <= mCnt + 1;
        mMatch = mEv && ((mP == 2'd0 && mS2) || (mP == 2'd1 && !mS2) || mP == 2'd2);
        mCe <= (mP != 2'd3) && (mSel ? mMatch : 1'b1);
      end
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (cmpOn && !done) begin
      check(countEn === mCe, "R4 R6 model countEn", int'(countEn), int'(mCe));
      check(cfgError === (mP == 2'd3), "R5 model cfgError", int'(cfgError), int'(mP == 2'd3));
    end
  end

  task automatic setCfg(logic [1:0] f, logic [1:0] p, logic s);
    @(negedge clk);
    enable = 0; cfgWr = 1; cfgFiltIn = f; cfgPolIn = p; cfgSelIn = s;
    @(negedge clk);
    cfgWr = 0;
  endtask

  task automatic hold(logic lvl, int n);
    @(negedge clk);
    pulseCnt += int'(countEn);
    extIn = lvl;
    repeat (n - 1) begin
      @(negedge clk);
      pulseCnt += int'(countEn);
    end
  endtask

  task automatic armAt(logic lvl);
    @(negedge clk);
    extIn = lvl; enable = 0;
    repeat (4) @(negedge clk);
    enable = 1;
    repeat (2) @(negedge clk);
    pulseCnt = 0;
  endtask

  task automatic glitchCase(logic [1:0] f, int width, int exp, string tag);
    setCfg(f, 2'd0, 1'b1);
    armAt(1'b0);
    hold(1'b1, width);
    hold(1'b0, 12);
    check(pulseCnt == exp, tag, pulseCnt, exp);
  endtask

  task automatic waveCase(logic [1:0] p, int exp, string tag);
    setCfg(2'd1, p, 1'b1);
    armAt(1'b0);
    for (int i = 0; i < 3; i++) begin
      hold(1'b1, 6);
      hold(1'b0, 6);
    end
    hold(1'b0, 6);
    check(pulseCnt == exp, tag, pulseCnt, exp);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    cmpOn = 1;
    // R9: reset state
    check(countEn == 0, "R9 countEn after reset", int'(countEn), 0);
    check(cfgError == 0, "R9 cfgError after reset", int'(cfgError), 0);
    // R9/R6: default selects internal tick
    enable = 1;
    @(negedge clk);
    check(countEn == 1, "R9 default internal tick", int'(countEn), 1);
    pulseCnt = 0;
    repeat (20) begin @(negedge clk); pulseCnt += int'(countEn); end
    check(pulseCnt == 20, "R6 internal tick every cycle", pulseCnt, 20);

    // R1: latency of the synchroniser path
    setCfg(2'd0, 2'd0, 1'b1);
    armAt(1'b0);
    extIn = 1;
    @(negedge clk); check(countEn == 0, "R1 edge+1", int'(countEn), 0);
    @(negedge clk); check(countEn == 0, "R1 edge+2", int'(countEn), 0);
    @(negedge clk); check(countEn == 1, "R1 edge+3", int'(countEn), 1);
    @(negedge clk); check(countEn == 0, "R1 single cycle", int'(countEn), 0);

    // R3: glitch lengths around each filter length
    glitchCase(2'd1, 1, 0, "R3 filt1 width1");
    glitchCase(2'd1, 2, 1, "R3 filt1 width2");
    glitchCase(2'd2, 3, 0, "R3 filt2 width3");
    glitchCase(2'd2, 4, 1, "R3 filt2 width4");
    glitchCase(2'd3, 7, 0, "R3 filt3 width7");
    glitchCase(2'd3, 8, 1, "R3 filt3 width8");
    // R3: restart on a single opposite sample
    setCfg(2'd3, 2'd0, 1'b1);
    armAt(1'b0);
    hold(1'b1, 5); hold(1'b0, 1); hold(1'b1, 5); hold(1'b0, 12);
    check(pulseCnt == 0, "R3 restart on interruption", pulseCnt, 0);

    // R2: no filter, every single-cycle toggle counts
    setCfg(2'd0, 2'd2, 1'b1);
    armAt(1'b0);
    for (int i = 0; i < 10; i++) hold(logic'(i % 2 == 0), 1);
    hold(1'b0, 5);
    check(pulseCnt == 10, "R2 one-cycle toggles", pulseCnt, 10);

    // R4: edge modes
    waveCase(2'd0, 3, "R4 rising only");
    waveCase(2'd1, 3, "R4 falling only");
    waveCase(2'd2, 6, "R4 both edges");

    // R5: illegal polarity
    setCfg(2'd0, 2'd3, 1'b1);
    @(negedge clk);
    check(cfgError == 1, "R5 error flagged", int'(cfgError), 1);
    armAt(1'b0);
    for (int i = 0; i < 4; i++) hold(logic'(i % 2 == 0), 4);
    check(pulseCnt == 0, "R5 external silent", pulseCnt, 0);
    setCfg(2'd0, 2'd3, 1'b0);
    armAt(1'b0);
    hold(1'b0, 10);
    check(pulseCnt == 0, "R5 internal silent", pulseCnt, 0);

    // R7: write while enabled is ignored
    setCfg(2'd0, 2'd0, 1'b1);
    armAt(1'b0);
    @(negedge clk); cfgWr = 1; cfgPolIn = 2'd3; cfgSelIn = 1'b0; cfgFiltIn = 2'd3;
    @(negedge clk); cfgWr = 0;
    check(cfgError == 0, "R7 locked write no error", int'(cfgError), 0);
    pulseCnt = 0;
    hold(1'b1, 4); hold(1'b0, 4); hold(1'b1, 4); hold(1'b0, 4);
    check(pulseCnt == 2, "R7 old mode kept", pulseCnt, 2);
    setCfg(2'd0, 2'd3, 1'b1);
    @(negedge clk);
    check(cfgError == 1, "R7 write taken when disabled", int'(cfgError), 1);

    // R8: level change while disabled gives no pulse
    setCfg(2'd0, 2'd0, 1'b1);
    armAt(1'b0);
    enable = 0;
    pulseCnt = 0;
    hold(1'b1, 6);
    check(pulseCnt == 0, "R8 quiet while disabled", pulseCnt, 0);
    enable = 1;
    hold(1'b1, 8);
    check(pulseCnt == 0, "R8 no stale edge", pulseCnt, 0);

    // Random phase, checked against the model
    for (int seg = 0; seg < 150; seg++) begin
      logic [1:0] p;
      p = 2'($urandom_range(0, 7) == 0 ? 3 : $urandom_range(0, 2));
      setCfg(2'($urandom_range(0, 3)), p, 1'($urandom_range(0, 5) != 0));
      extIn = 1'($urandom_range(0, 1));
      repeat (3) @(negedge clk);
      enable = 1;
      for (int st = 0; st < 12; st++) begin
        extIn = 1'($urandom_range(0, 1));
        cfgWr = ($urandom_range(0, 6) == 0);
        cfgFiltIn = 2'($urandom_range(0, 3));
        cfgPolIn = 2'($urandom_range(0, 3));
        cfgSelIn = 1'($urandom_range(0, 1));
        if ($urandom_range(0, 15) == 0) enable = 0;
        else enable = 1;
        repeat ($urandom_range(1, 10)) @(negedge clk);
        cfgWr = 0;
      end
    end

    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule